// File: doc/BRIEF.md
# Tile Layer Scroll Address Generator

This block sits at the front of a tile-layer pixel pipeline. For each requested screen pixel (column 0..495, line 0..383) on one of four tile layers, it turns the layer's 32-bit scroll word into a position on a 512x512 pixel tile map. It then emits the name-table word address, the half of that word that holds the tile entry, and the pixel row and column inside the 8x8 tile. The pattern-fetch stage takes these outputs as they are.

The horizontal offset comes from one of two sources. It is either the value held in the scroll word, or a 16-bit per-line value read from a table in video memory. A control bit in the scroll word picks the source. When the table is used, the block reads the table word once at the first pixel of a new line and holds the pixel request (ready low) until the read completes. Both map axes wrap on their own. A layer whose enable bit is clear still produces coordinates, but its output carries a cleared enable tag.

Top module: `tmap_scroll_agen`

## Requirements
- R1: After reset, `out_valid` and `rd_req` are 0, and `in_ready` is 1 while no line-table read is needed.
- R2: The scroll word fields are: enable = bit 31, vertical offset = bits 25:16, line-table select = bit 15, horizontal offset = bits 9:0. The map position is mx = (x + h) mod 512 and my = (y + v) mod 512. `out_row` = my[2:0] and `out_col` = mx[2:0].
- R3: Tile index = my[8:3]*64 + mx[8:3]. `out_addr` = 0x3E000 + layer*0x800 + index/2, a 32-bit word address. `out_half_hi` is 1 when the index is even and 0 when it is odd.
- R4: A sum at or beyond 512 wraps on each axis independently. Offset bit 9 has no effect.
- R5: With the select bit set, the block reads the word at 0x3D800 + layer*0x100 + y/2. It uses bits 31:16 of that word when y is even and bits 15:0 when y is odd. Only the low 9 bits of the chosen value act as h.
- R6: Further pixels on the same layer and line read nothing more from memory.
- R7: A request that needs a table read is held with `in_ready` low until `rd_ack`. `rd_addr` holds steady while `rd_req` is high.
- R8: A pixel with enable clear is still accepted and mapped, and `out_enabled` is 0. With enable set, `out_enabled` is 1.
- R9: An accepted request shows on the outputs exactly one cycle later, for one cycle, unless another request is accepted.
- R10: Scroll word bits 30:26 and 14:10 have no effect on any output.
- R11: A change of layer number, with the select bit set, starts a new table read even on the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel request present |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_layer | input | 2 | Layer number 0..3 |
| in_x | input | 9 | Screen column |
| in_y | input | 9 | Screen line |
| in_scroll | input | 32 | Scroll word of the selected layer |
| rd_req | output | 1 | Line-table read request |
| rd_addr | output | 18 | Line-table word address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| out_valid | output | 1 | Coordinates valid |
| out_enabled | output | 1 | Layer enable tag |
| out_addr | output | 18 | Name-table word address |
| out_half_hi | output | 1 | Entry sits in bits 31:16 |
| out_row | output | 3 | Pixel row in tile |
| out_col | output | 3 | Pixel column in tile |

## Verification
The bench drives positions whose sums cross 512 on one axis but not the other. A design that carries between the axes, or that keeps offset bit 9, would show wrong tile numbers here. Odd and even lines and tile indices are set side by side, so a swapped half-select would pick the wrong table value or the wrong name entry. Read traffic is counted while the line stays the same and while the layer changes on one line. A design that refetches would show extra reads, and one that keys its cache on the line alone would show a missing read. Junk in the unused scroll bits, and a disabled layer, would expose field decoding that is too wide or a layer that is dropped instead of tagged.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int unsigned COORD_W = 9;   // 512-pixel map per axis
  localparam int unsigned TILE_SH = 3;   // 8x8 pixel tiles
  localparam int unsigned TILE_W  = COORD_W - TILE_SH;
  localparam int unsigned INDEX_W = 2 * TILE_W;

  typedef struct packed {
    logic               enable;
    logic [COORD_W-1:0] vofs;
    logic               line_sel;
    logic [COORD_W-1:0] hofs;
  } scroll_f_t;

  function automatic scroll_f_t unpack_scroll(input logic [31:0] w);
    scroll_f_t f;
    f.enable   = w[31];
    f.vofs     = w[16 +: COORD_W];
    f.line_sel = w[15];
    f.hofs     = w[0 +: COORD_W];
    return f;
  endfunction
endpackage

// File: rtl/tsa_coord_map.sv
module tsa_coord_map
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned NUM_LAYERS  = 4,
  parameter int unsigned NAME_BASE   = 32'h3E000,
  parameter int unsigned NAME_STRIDE = 32'h800,
  localparam int unsigned LAYER_W    = $clog2(NUM_LAYERS)
) (
  input  logic [LAYER_W-1:0] layer,
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic [COORD_W-1:0] hofs,
  input  logic [COORD_W-1:0] vofs,
  output logic [ADDR_W-1:0]  word_addr,
  output logic               half_hi,
  output logic [TILE_SH-1:0] row,
  output logic [TILE_SH-1:0] col
);
  logic [ADDR_W-1:0]  base_tab [NUM_LAYERS];
  logic [COORD_W-1:0] mx, my;
  logic [INDEX_W-1:0] idx;

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_base
    assign base_tab[g] = ADDR_W'(NAME_BASE + g * NAME_STRIDE);
  end

  always_comb begin
    mx        = px + hofs;   // natural wrap at 512
    my        = py + vofs;
    idx       = {my[COORD_W-1:TILE_SH], mx[COORD_W-1:TILE_SH]};
    word_addr = base_tab[layer] + ADDR_W'(idx[INDEX_W-1:1]);
    half_hi   = ~idx[0];
    row       = my[TILE_SH-1:0];
    col       = mx[TILE_SH-1:0];
  end
endmodule

// File: rtl/tsa_line_cache.sv
module tsa_line_cache
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned NUM_LAYERS  = 4,
  parameter int unsigned LINE_BASE   = 32'h3D800,
  parameter int unsigned LINE_STRIDE = 32'h100,
  localparam int unsigned LAYER_W    = $clog2(NUM_LAYERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lookup,
  input  logic [LAYER_W-1:0] layer,
  input  logic [COORD_W-1:0] line,
  output logic               miss,
  output logic               busy,
  output logic [COORD_W-1:0] line_hofs,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ack,
  input  logic [31:0]        rd_data
);
  typedef enum logic {ST_IDLE, ST_FETCH} st_t;

  st_t                st_q, st_d;
  logic               tag_vld_q, tag_vld_d;
  logic [LAYER_W-1:0] tag_layer_q, tag_layer_d;
  logic [COORD_W-1:0] tag_line_q, tag_line_d;
  logic [COORD_W-1:0] hofs_q, hofs_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [ADDR_W-1:0]  base_tab [NUM_LAYERS];

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_base
    assign base_tab[g] = ADDR_W'(LINE_BASE + g * LINE_STRIDE);
  end

  assign miss = lookup && !(tag_vld_q && tag_layer_q == layer && tag_line_q == line);

  always_comb begin
    st_d        = st_q;
    tag_vld_d   = tag_vld_q;
    tag_layer_d = tag_layer_q;
    tag_line_d  = tag_line_q;
    hofs_d      = hofs_q;
    addr_d      = addr_q;
    unique case (st_q)
      ST_IDLE: if (miss) begin
        st_d        = ST_FETCH;
        tag_vld_d   = 1'b0;
        tag_layer_d = layer;
        tag_line_d  = line;
        addr_d      = base_tab[layer] + ADDR_W'(line[COORD_W-1:1]);
      end
      ST_FETCH: if (rd_ack) begin
        st_d      = ST_IDLE;
        tag_vld_d = 1'b1;
        hofs_d    = tag_line_q[0] ? rd_data[COORD_W-1:0] : rd_data[16 +: COORD_W];
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      tag_vld_q   <= 1'b0;
      tag_layer_q <= '0;
      tag_line_q  <= '0;
      hofs_q      <= '0;
      addr_q      <= '0;
    end else begin
      st_q        <= st_d;
      tag_vld_q   <= tag_vld_d;
      tag_layer_q <= tag_layer_d;
      tag_line_q  <= tag_line_d;
      hofs_q      <= hofs_d;
      addr_q      <= addr_d;
    end
  end

  assign busy      = (st_q == ST_FETCH);
  assign rd_req    = busy;
  assign rd_addr   = addr_q;
  assign line_hofs = hofs_q;

  logic unused_data;
  assign unused_data = ^{rd_data[31:16+COORD_W], rd_data[15:COORD_W]};

  // R7: address held for the whole read
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R6: a completed read is not repeated at once
  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> !rd_req);
endmodule

// File: rtl/tmap_scroll_agen.sv
module tmap_scroll_agen
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned NUM_LAYERS  = 4,
  parameter int unsigned NAME_BASE   = 32'h3E000,
  parameter int unsigned NAME_STRIDE = 32'h800,
  parameter int unsigned LINE_BASE   = 32'h3D800,
  parameter int unsigned LINE_STRIDE = 32'h100,
  localparam int unsigned LAYER_W    = $clog2(NUM_LAYERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LAYER_W-1:0] in_layer,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [31:0]        in_scroll,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ack,
  input  logic [31:0]        rd_data,
  output logic               out_valid,
  output logic               out_enabled,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               out_half_hi,
  output logic [TILE_SH-1:0] out_row,
  output logic [TILE_SH-1:0] out_col
);
  scroll_f_t          fld;
  logic               miss, busy, accept;
  logic [COORD_W-1:0] line_hofs, hofs_sel;
  logic [ADDR_W-1:0]  map_addr;
  logic               map_half;
  logic [TILE_SH-1:0] map_row, map_col;

  assign fld = unpack_scroll(in_scroll);

  tsa_line_cache #(
    .ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS),
    .LINE_BASE(LINE_BASE), .LINE_STRIDE(LINE_STRIDE)
  ) u_cache (
    .clk(clk), .rst_n(rst_n),
    .lookup(in_valid && fld.line_sel),
    .layer(in_layer), .line(in_y),
    .miss(miss), .busy(busy), .line_hofs(line_hofs),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  assign hofs_sel = fld.line_sel ? line_hofs : fld.hofs;

  tsa_coord_map #(
    .ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS),
    .NAME_BASE(NAME_BASE), .NAME_STRIDE(NAME_STRIDE)
  ) u_map (
    .layer(in_layer), .px(in_x), .py(in_y),
    .hofs(hofs_sel), .vofs(fld.vofs),
    .word_addr(map_addr), .half_hi(map_half),
    .row(map_row), .col(map_col)
  );

  assign in_ready = !busy && !miss;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_enabled <= 1'b0;
      out_addr    <= '0;
      out_half_hi <= 1'b0;
      out_row     <= '0;
      out_col     <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_enabled <= fld.enable;
        out_addr    <= map_addr;
        out_half_hi <= map_half;
        out_row     <= map_row;
        out_col     <= map_col;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{in_scroll[30:16+COORD_W], in_scroll[14:COORD_W]};

  // R9: accepted request appears one cycle later
  a_r9_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R9: nothing appears without an acceptance
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);
  // R7: no acceptance while a table read is open
  a_r7_stall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !in_ready);
  // R8: enable tag follows the accepted scroll word
  a_r8_enable_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_enabled == $past(in_scroll[31])));
endmodule

// File: tb/tb_tmap_scroll_agen.sv
module tb_tmap_scroll_agen;
  logic        clk, rst_n;
  logic        in_valid, in_ready;
  logic [1:0]  in_layer;
  logic [8:0]  in_x, in_y;
  logic [31:0] in_scroll;
  logic        rd_req, rd_ack;
  logic [17:0] rd_addr;
  logic [31:0] rd_data;
  logic        out_valid, out_enabled, out_half_hi;
  logic [17:0] out_addr;
  logic [2:0]  out_row, out_col;

  int checks = 0, errors = 0, reads = 0, dly = 0;
  logic [17:0] last_rd_addr;

  tmap_scroll_agen dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [17:0] a);
    return {16'(a * 7 + 16'h0100), 16'(a * 13 + 16'h0203)};
  endfunction

  always @(posedge clk) begin
    rd_ack <= 1'b0;
    if (rd_req && !rd_ack) begin
      if (dly == 2) begin
        rd_ack <= 1'b1; rd_data <= mem_word(rd_addr);
        last_rd_addr <= rd_addr; reads <= reads + 1; dly <= 0;
      end else dly <= dly + 1;
    end
  end

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired: act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input int v, input bit ls, input int h);
    return {en, 5'b0, 10'(v), ls, 5'b0, 10'(h)};
  endfunction

  // drive one pixel; returns number of stall cycles
  task automatic px(input int layer, input int x, input int y, input logic [31:0] sc,
                    output int stalls);
    stalls = 0;
    in_valid = 1'b1; in_layer = 2'(layer); in_x = 9'(x); in_y = 9'(y); in_scroll = sc;
    forever begin
      #1;
      if (in_ready) break;
      if (stalls > 0 && out_valid) chk("R7 out_valid during stall", 32'(out_valid), 0);
      @(negedge clk); stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input int layer, input int x, input int y,
                            input int h, input int v, input bit en);
    int mx, my, idx;
    mx = (x + (h % 512)) % 512; my = (y + (v % 512)) % 512;
    idx = (my / 8) * 64 + (mx / 8);
    chk({req, " valid"}, 32'(out_valid), 1);
    chk({req, " addr"}, 32'(out_addr), 32'h3E000 + layer * 32'h800 + idx / 2);
    chk({req, " half"}, 32'(out_half_hi), 32'((idx % 2) == 0));
    chk({req, " row"}, 32'(out_row), 32'(my % 8));
    chk({req, " col"}, 32'(out_col), 32'(mx % 8));
    chk({req, " enabled"}, 32'(out_enabled), 32'(en));
  endtask

  function automatic int line_h(input int layer, input int y);
    logic [31:0] w;
    w = mem_word(18'(32'h3D800 + layer * 32'h100 + y / 2));
    return (y % 2 == 0) ? int'(w[24:16]) : int'(w[8:0]);
  endfunction

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_register_scroll();
    int s;
    px(0, 0, 0, mk(1, 0, 0, 0), s);       expect_out("R2 origin", 0, 0, 0, 0, 0, 1);
    px(1, 13, 22, mk(1, 5, 0, 17), s);    expect_out("R2 l1", 1, 13, 22, 17, 5, 1);
    px(2, 495, 383, mk(1, 0, 0, 0), s);   expect_out("R3 corner l2", 2, 495, 383, 0, 0, 1);
    px(3, 8, 0, mk(1, 0, 0, 0), s);       expect_out("R3 odd index l3", 3, 8, 0, 0, 0, 1);
    chk("R6 no read in register mode", 32'(reads), 0);
  endtask

  task automatic t_latency();
    int s;
    px(0, 40, 40, mk(1, 1, 0, 1), s);
    expect_out("R9 one cycle", 0, 40, 40, 1, 1, 1);
    @(negedge clk);
    chk("R9 single pulse", 32'(out_valid), 0);
  endtask

  task automatic t_wrap();
    int s;
    px(0, 490, 10, mk(1, 3, 0, 30), s);    expect_out("R4 x wraps only", 0, 490, 10, 30, 3, 1);
    px(1, 4, 380, mk(1, 200, 0, 2), s);    expect_out("R4 y wraps only", 1, 4, 380, 2, 200, 1);
    px(2, 100, 100, mk(1, 1023, 0, 1023), s);
    expect_out("R4 bit9 ignored", 2, 100, 100, 511, 511, 1);
  endtask

  task automatic t_line_scroll();
    int s, r0;
    r0 = reads;
    px(1, 0, 10, mk(1, 0, 1, 99), s);
    chk("R7 stalled on miss", 32'(s > 0), 1);
    chk("R5 one read", 32'(reads - r0), 1);
    chk("R5 table addr even", 32'(last_rd_addr), 32'h3D800 + 32'h100 + 5);
    expect_out("R5 even line high half", 1, 0, 10, line_h(1, 10), 0, 1);
    px(1, 9, 10, mk(1, 0, 1, 99), s);
    chk("R6 no stall same line", 32'(s), 0);
    chk("R6 no extra read", 32'(reads - r0), 1);
    expect_out("R6 cached value", 1, 9, 10, line_h(1, 10), 0, 1);
    px(1, 0, 11, mk(1, 7, 1, 0), s);
    chk("R5 new line reads", 32'(reads - r0), 2);
    chk("R5 table addr odd", 32'(last_rd_addr), 32'h3D800 + 32'h100 + 5);
    expect_out("R5 odd line low half", 1, 0, 11, line_h(1, 11), 7, 1);
    px(3, 0, 11, mk(1, 0, 1, 0), s);
    chk("R11 layer change reads", 32'(reads - r0), 3);
    chk("R11 table addr l3", 32'(last_rd_addr), 32'h3D800 + 3 * 32'h100 + 5);
    expect_out("R11 layer3 value", 3, 0, 11, line_h(3, 11), 0, 1);
  endtask

  task automatic t_disabled();
    int s;
    px(2, 50, 60, mk(0, 4, 0, 6), s);
    expect_out("R8 disabled still mapped", 2, 50, 60, 6, 4, 0);
  endtask

  task automatic t_ignored_bits();
    int s;
    logic [31:0] sc;
    sc = mk(1, 12, 0, 34) | 32'h7C00_7C00;
    px(0, 77, 88, sc, s);
    expect_out("R10 junk bits ignored", 0, 77, 88, 34, 12, 1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_layer = '0; in_x = '0; in_y = '0; in_scroll = '0;
    rd_ack = 1'b0; rd_data = '0; last_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register_scroll();
    t_latency();
    t_wrap();
    t_line_scroll();
    t_disabled();
    t_ignored_bits();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule